// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block connects the waveform side of an 8-bit timer to one general-purpose I/O pin. It keeps a one-bit output-compare state register inside the block. A compare-match pulse from the timer updates that register according to a 2-bit action mode. The mode either leaves the state alone, inverts it, clears it or sets it.

Software writes the action mode through a write strobe. The new value only governs the next compare match, not one that falls on the same edge as the write. A force strobe applies the configured action at once, but only while the timer runs in a non-PWM waveform mode. Software can also load the compare state directly, for example before the pin is enabled as an output.

On the pin side, any nonzero action mode replaces the port data bit with the compare state. The data direction bit alone drives the output enable.

Top module: `ocu_compare_pin`

## Requirements
- R1: A synchronous reset clears the compare state and the action mode to zero. After reset, pin_out equals port_bit.
- R2: With action mode 00 (mode_wr_val encoding 2'b00), a compare match leaves the compare state unchanged.
- R3: When the stored action mode is nonzero, pin_out carries the compare state. When it is 00, pin_out carries port_bit. This choice does not depend on pwm_mode.
- R4: pin_oe equals ddr_bit in every cycle, whatever the action mode.
- R5: On a compare match, mode 01 inverts the compare state, mode 10 clears it and mode 11 sets it.
- R6: A mode write takes effect from the first compare match after the edge that stores it. A match on the same edge as the write still uses the previous mode.
- R7: With pwm_mode=0, force_cmp applies the stored action at that clock edge. A force and a match on the same edge apply the action only once.
- R8: With pwm_mode=1, force_cmp has no effect on the compare state. Compare matches apply the same action table as in R5.
- R9: oc_wr_en loads oc_wr_val into the compare state and takes priority over a match or force on the same edge. It works while ddr_bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_match | input | 1 | One-cycle compare-match pulse from the timer |
| pwm_mode | input | 1 | 1 = PWM waveform mode, 0 = normal/clear-on-match mode |
| mode_wr_en | input | 1 | Strobe that stores mode_wr_val as the action mode |
| mode_wr_val | input | 2 | Action mode: 00 none, 01 invert, 10 clear, 11 set |
| force_cmp | input | 1 | Strobe that applies the action without a match |
| oc_wr_en | input | 1 | Strobe that loads the compare state directly |
| oc_wr_val | input | 1 | Value loaded by oc_wr_en |
| port_bit | input | 1 | Port data bit used when no override is active |
| ddr_bit | input | 1 | Data direction bit, 1 = output |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The action table is driven with matches under each of the four modes, both toggle directions and repeated set/clear, so an exchanged mode encoding shows up as a wrong pin level. A mode write landing on the same edge as a match separates delayed adoption from immediate adoption. Forces are tried with and without a coincident match and in both waveform modes, which distinguishes double application and a missing PWM gate. Port and state are held at opposite levels when the mode changes, direction is dropped while the override is active, and direct loads are made with the pin disabled, so that the override selection, the enable path and the load priority can each fail visibly.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        CMP_NONE   = 2'b00,
        CMP_INVERT = 2'b01,
        CMP_CLEAR  = 2'b10,
        CMP_SET    = 2'b11
    } cmp_mode_e;

    typedef struct packed {
        logic match;
        logic force_req;
        logic pwm;
        logic load;
        logic load_val;
    } oc_event_t;

    // Next compare state for an action applied to the current state.
    function automatic logic apply_action(cmp_mode_e m, logic cur);
        logic nxt;
        unique case (m)
            CMP_INVERT: nxt = ~cur;
            CMP_CLEAR:  nxt = 1'b0;
            CMP_SET:    nxt = 1'b1;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic mode_overrides(cmp_mode_e m);
        return m != CMP_NONE;
    endfunction

endpackage

// File: rtl/ocu_mode_reg.sv
module ocu_mode_reg
    import ocu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [MODE_W-1:0]   wr_val,
    output cmp_mode_e           mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CMP_NONE;
        end else if (wr_en) begin
            mode_q <= cmp_mode_e'(wr_val);
        end
    end

endmodule

// File: rtl/ocu_state.sv
module ocu_state
    import ocu_pkg::*;
#(
    parameter logic RESET_OC = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  cmp_mode_e   mode,
    input  oc_event_t   ev,
    output logic        oc_q
);

    logic fire;
    logic oc_d;

    // A force only counts outside PWM; coincident force and match fire once.
    assign fire = ev.match | (ev.force_req & ~ev.pwm);

    always_comb begin
        oc_d = oc_q;
        if (ev.load) begin
            oc_d = ev.load_val;
        end else if (fire) begin
            oc_d = apply_action(mode, oc_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_q <= RESET_OC;
        end else begin
            oc_q <= oc_d;
        end
    end

endmodule

// File: rtl/ocu_pin_mux.sv
module ocu_pin_mux
    import ocu_pkg::*;
(
    input  cmp_mode_e   mode,
    input  logic        oc,
    input  logic        port_bit,
    input  logic        ddr_bit,
    output logic        pin_out,
    output logic        pin_oe
);

    always_comb begin
        pin_out = mode_overrides(mode) ? oc : port_bit;
        pin_oe  = ddr_bit;
    end

endmodule

// File: rtl/ocu_compare_pin.sv
module ocu_compare_pin
    import ocu_pkg::*;
#(
    parameter logic RESET_OC = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmp_match,
    input  logic                pwm_mode,
    input  logic                mode_wr_en,
    input  logic [MODE_W-1:0]   mode_wr_val,
    input  logic                force_cmp,
    input  logic                oc_wr_en,
    input  logic                oc_wr_val,
    input  logic                port_bit,
    input  logic                ddr_bit,
    output logic                pin_out,
    output logic                pin_oe
);

    cmp_mode_e mode_q;
    logic      oc_q;
    oc_event_t ev;

    assign ev = '{match:     cmp_match,
                  force_req: force_cmp,
                  pwm:       pwm_mode,
                  load:      oc_wr_en,
                  load_val:  oc_wr_val};

    ocu_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (mode_wr_en),
        .wr_val (mode_wr_val),
        .mode_q (mode_q)
    );

    ocu_state #(.RESET_OC(RESET_OC)) u_state (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_q),
        .ev   (ev),
        .oc_q (oc_q)
    );

    ocu_pin_mux u_mux (
        .mode     (mode_q),
        .oc       (oc_q),
        .port_bit (port_bit),
        .ddr_bit  (ddr_bit),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

endmodule

// File: rtl/ocu_compare_pin_chk.sv
module ocu_compare_pin_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmp_match,
    input logic       pwm_mode,
    input logic       force_cmp,
    input logic       oc_wr_en,
    input logic       oc_wr_val,
    input logic       port_bit,
    input logic       ddr_bit,
    input logic       pin_out,
    input logic       pin_oe,
    input logic [1:0] mode_q,
    input logic       oc_q
);

    // R2: idle mode never moves the state
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b00 && !oc_wr_en) |=> $stable(oc_q));

    // R3: no override means the port bit reaches the pin
    a_r3_port_passthru: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b00) |-> (pin_out == port_bit));

    // R4: enable follows direction bit
    a_r4_oe_is_ddr: assert property (@(posedge clk) disable iff (rst)
        pin_oe == ddr_bit);

    // R5: invert mode flips the state on a match
    a_r5_invert_flips: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b01 && cmp_match && !oc_wr_en) |=> (oc_q != $past(oc_q)));

    // R8: force alone in PWM leaves the state
    a_r8_pwm_force_ignored: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && force_cmp && !cmp_match && !oc_wr_en) |=> $stable(oc_q));

    // R9: direct load wins
    a_r9_direct_load: assert property (@(posedge clk) disable iff (rst)
        oc_wr_en |=> (oc_q == $past(oc_wr_val)));

endmodule

bind ocu_compare_pin ocu_compare_pin_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmp_match (cmp_match),
    .pwm_mode  (pwm_mode),
    .force_cmp (force_cmp),
    .oc_wr_en  (oc_wr_en),
    .oc_wr_val (oc_wr_val),
    .port_bit  (port_bit),
    .ddr_bit   (ddr_bit),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mode_q    (mode_q),
    .oc_q      (oc_q)
);

// File: tb/ocu_compare_pin_tb.sv
module ocu_compare_pin_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmp_match, pwm_mode, mode_wr_en, force_cmp;
    logic [1:0] mode_wr_val;
    logic       oc_wr_en, oc_wr_val, port_bit, ddr_bit;
    logic       pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ocu_compare_pin u_dut (
        .clk(clk), .rst(rst), .cmp_match(cmp_match), .pwm_mode(pwm_mode),
        .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val), .force_cmp(force_cmp),
        .oc_wr_en(oc_wr_en), .oc_wr_val(oc_wr_val), .port_bit(port_bit),
        .ddr_bit(ddr_bit), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Fields: mode_wr_en, mode_wr_val[1:0], cmp_match, force_cmp, pwm_mode,
    //         oc_wr_en, oc_wr_val, port_bit, ddr_bit, exp_out, exp_oe
    localparam int NV = 20;
    localparam logic [11:0] VEC [NV] = '{
        12'b0_00_0_0_0_0_0_1_1_1_1, // R1 idle after reset: port passes
        12'b0_00_1_0_0_0_0_0_1_0_1, // R2 match in mode 00
        12'b1_01_0_0_0_0_0_0_1_0_1, // R3 override selects state 0
        12'b0_00_1_0_0_0_0_0_1_1_1, // R5 invert -> 1
        12'b0_00_1_0_0_0_0_0_1_0_1, // R5 invert -> 0
        12'b1_11_1_0_0_0_0_0_1_1_1, // R6 write+match uses old invert
        12'b0_00_0_0_0_1_0_0_1_0_1, // R9 load 0
        12'b0_00_1_0_0_0_0_0_1_1_1, // R5 set
        12'b1_10_0_0_0_0_0_0_1_1_1, // R6 write clear, no match: hold
        12'b0_00_0_1_0_0_0_1_1_0_1, // R7 force clears
        12'b1_01_0_0_0_0_0_1_1_0_1, // R3 mode invert, state 0 over port 1
        12'b0_00_0_1_1_0_0_1_1_0_1, // R8 force in PWM ignored
        12'b0_00_1_0_1_0_0_1_1_1_1, // R8 match in PWM inverts
        12'b0_00_0_0_0_0_0_1_0_1_0, // R4 ddr 0 drops enable
        12'b1_00_0_0_1_0_0_0_1_0_1, // R3 mode 00 returns port
        12'b1_01_0_1_0_1_0_0_1_0_1, // R9 load beats force
        12'b0_00_1_1_0_0_0_0_1_1_1, // R7 force+match invert once
        12'b0_00_0_0_1_0_0_0_1_1_1, // R3 override independent of PWM
        12'b1_10_0_0_0_0_0_1_1_1_1, // R6 clear stored, not yet applied
        12'b0_00_1_0_0_0_0_1_1_0_1  // R5 clear on match
    };
    localparam int VREQ [NV] = '{1,2,3,5,5,6,9,5,6,7,3,8,8,4,3,9,7,3,6,5};

    task automatic idle_inputs();
        cmp_match = 0; pwm_mode = 0; mode_wr_en = 0; mode_wr_val = 0;
        force_cmp = 0; oc_wr_en = 0; oc_wr_val = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic eo, logic eoe);
        checks++;
        if (pin_out !== eo || pin_oe !== eoe) begin
            errors++;
            $display("FAIL %s: pin_out=%b pin_oe=%b expected pin_out=%b pin_oe=%b",
                     req, pin_out, pin_oe, eo, eoe);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        port_bit = 1; ddr_bit = 1; rst = 1;
        @(negedge clk);
        tick();
        check("R1", 1'b1, 1'b1);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            {mode_wr_en, mode_wr_val, cmp_match, force_cmp, pwm_mode,
             oc_wr_en, oc_wr_val, port_bit, ddr_bit} = VEC[i][11:2];
            tick();
            checks++;
            if (pin_out !== VEC[i][1] || pin_oe !== VEC[i][0]) begin
                errors++;
                $display("FAIL R%0d vec %0d: pin_out=%b pin_oe=%b expected pin_out=%b pin_oe=%b",
                         VREQ[i], i, pin_out, pin_oe, VEC[i][1], VEC[i][0]);
            end
            idle_inputs();
        end

        // R1: mid-run reset clears state and mode
        oc_wr_en = 1; oc_wr_val = 1; port_bit = 0; ddr_bit = 1;
        tick();
        check("R9", 1'b1, 1'b1);          // mode 10 active, state loaded 1
        idle_inputs();
        rst = 1; port_bit = 1;
        tick();
        rst = 0;
        check("R1", 1'b1, 1'b1);          // mode cleared: port passes
        mode_wr_en = 1; mode_wr_val = 2'b01; port_bit = 1;
        tick();
        idle_inputs();
        check("R1", 1'b0, 1'b1);          // state was cleared by reset

        // R9: initialise state while pin is an input
        ddr_bit = 0; oc_wr_en = 1; oc_wr_val = 1; port_bit = 0;
        tick();
        idle_inputs();
        check("R9", 1'b1, 1'b0);
        ddr_bit = 1;
        #0.1;
        check("R4", 1'b1, 1'b1);

        // R6: mode write (11) after a matching edge, then match applies it
        oc_wr_en = 1; oc_wr_val = 0;
        tick();
        idle_inputs();
        mode_wr_en = 1; mode_wr_val = 2'b11;
        tick();
        idle_inputs();
        check("R6", 1'b0, 1'b1);
        cmp_match = 1;
        tick();
        idle_inputs();
        check("R6", 1'b1, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule